// File: doc/BRIEF.md
# One-Time-Programmable Fuse Bank Controller

This block holds a bank of one-time-programmable bits, 320 by default, arranged as ten 32-bit words. Software reaches it through a small synchronous register port. Writes are taken on the rising clock edge. Reads are combinational from the address.

Each fuse word has its own read-only status offset. A programmed bit reads as 1 and an unprogrammed bit reads as 0. To program, software first loads a 32-bit data register, then writes a command that carries the target word index. After a fixed number of busy cycles, the data value is ORed into that word, so a bit can only ever be set.

A mask bit can be written once. When it is set, readback of every word except word 0 is blanked. The `supplyOk` input models the fuse power rail. While the rail is floating, every fuse word reads as all ones and programming is refused. In this model the fuse storage is ordinary flip-flops that reset clears.

Top module: `fuse_bank`

## Requirements
- R1: After reset every fuse word reads 0, the status offset (13) reads 0x8 while `supplyOk` is high, and the data register (offset 10) reads 0.
- R2: A read of offset n, for n from 0 to 9, returns fuse word n when the supply is present and the mask does not apply. Word 0 and word 9 are both reachable.
- R3: A write to the command offset (11) uses its SEL field in bits [3:0] to OR the current data register into word SEL. Bits already set stay set whatever the data holds.
- R4: An accepted command holds status bit 0 (busy) high for exactly PROG_CYCLES cycles, 8 by default. The word is updated when busy falls. A command written while busy is ignored and sets no error.
- R5: A command with SEL above 9, issued while not busy, changes no word and sets the sticky error flag (status bit 1).
- R6: The first write to the mask offset (12) after reset copies its bit 0 into the mask, which status bit 2 shows. Every later mask write is ignored until reset.
- R7: While the mask is 1 and the supply is present, offsets 1 to 9 read 0 and offset 0 still returns word 0.
- R8: While `supplyOk` is low, offsets 0 to 9 read 0xFFFFFFFF regardless of the mask. Status bit 3 follows `supplyOk`.
- R9: A command issued while `supplyOk` is low is rejected. Busy stays low, no word changes and the error flag is set.
- R10: The data register reads back at offset 10. Offsets 11, 14 and 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyOk | input | 1 | Fuse rail present (0 = floating) |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 4 | Register offset |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for `busAddr` |

## Verification
The hardest situations to reach are a command that arrives while programming is still running, and the interaction of the floating rail with the mask. The stimulus issues a second command in the cycle right after an accepted one. It then programs two different values into the same word to show that bits accumulate. The rail is dropped while the mask is set, and again while a command is written, so that all three read and program paths are exercised. A behavioural model in the bench predicts the read data on every clock.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int NUM_WORDS   = 10;
  localparam int WORD_W      = 32;
  localparam int ADDR_W      = 4;
  localparam int SEL_W       = 4;
  localparam int PROG_CYCLES = 8;

  // register offsets
  localparam int OFF_DATA = 10;
  localparam int OFF_CMD  = 11;
  localparam int OFF_MASK = 12;
  localparam int OFF_STAT = 13;

  // status bit positions
  localparam int ST_BUSY   = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_MASK   = 2;
  localparam int ST_SUPPLY = 3;

  typedef struct packed {
    logic loadData;
    logic latchCmd;
    logic commit;
    logic setMask;
  } fuseStrobe_t;
endpackage

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
  import fuse_pkg::*;
#(
  parameter int NUM_W   = NUM_WORDS,
  parameter int ADR_W   = ADDR_W,
  parameter int SL_W    = SEL_W,
  parameter int P_CYC   = PROG_CYCLES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyOk,
  input  logic              busWrEn,
  input  logic [ADR_W-1:0]  busAddr,
  input  logic [SL_W-1:0]   selIn,
  output fuseStrobe_t       strobe,
  output logic              busy,
  output logic              errFlag,
  output logic              maskLocked
);
  localparam int CNT_W = $clog2(P_CYC + 1);
  localparam logic [ADR_W-1:0] ADR_DATA = ADR_W'(OFF_DATA);
  localparam logic [ADR_W-1:0] ADR_CMD  = ADR_W'(OFF_CMD);
  localparam logic [ADR_W-1:0] ADR_MASK = ADR_W'(OFF_MASK);
  localparam logic [SL_W-1:0]  SEL_LIM  = SL_W'(NUM_W);

  logic [CNT_W-1:0] progCnt;
  logic wrCmd, selValid, accept, reject, commitNow, commitFail;

  assign busy       = (progCnt != '0);
  assign wrCmd      = busWrEn && (busAddr == ADR_CMD);
  assign selValid   = (selIn < SEL_LIM);
  assign accept     = wrCmd && !busy && supplyOk && selValid;
  assign reject     = wrCmd && !busy && (!supplyOk || !selValid);
  assign commitNow  = (progCnt == CNT_W'(1));
  assign commitFail = commitNow && !supplyOk;

  always_comb begin
    strobe          = '0;
    strobe.loadData = busWrEn && (busAddr == ADR_DATA);
    strobe.latchCmd = accept;
    strobe.commit   = commitNow && supplyOk;
    strobe.setMask  = busWrEn && (busAddr == ADR_MASK) && !maskLocked;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progCnt    <= '0;
      errFlag    <= 1'b0;
      maskLocked <= 1'b0;
    end else begin
      if (accept)
        progCnt <= CNT_W'(P_CYC);
      else if (busy)
        progCnt <= progCnt - 1'b1;
      if (reject || commitFail)
        errFlag <= 1'b1;
      if (strobe.setMask)
        maskLocked <= 1'b1;
    end
  end
endmodule

// File: rtl/fuse_datapath.sv
module fuse_datapath
  import fuse_pkg::*;
#(
  parameter int NUM_W = NUM_WORDS,
  parameter int WD_W  = WORD_W,
  parameter int ADR_W = ADDR_W,
  parameter int SL_W  = SEL_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fuseStrobe_t          strobe,
  input  logic                 supplyOk,
  input  logic                 busy,
  input  logic                 errFlag,
  input  logic [ADR_W-1:0]     busAddr,
  input  logic [WD_W-1:0]      busWrData,
  output logic [WD_W-1:0]      busRdData,
  output logic [NUM_W*WD_W-1:0] fuseArray,
  output logic                 maskOn
);
  localparam logic [ADR_W-1:0] ADR_DATA = ADR_W'(OFF_DATA);
  localparam logic [ADR_W-1:0] ADR_MASK = ADR_W'(OFF_MASK);
  localparam logic [ADR_W-1:0] ADR_STAT = ADR_W'(OFF_STAT);

  logic [WD_W-1:0] dataReg;
  logic [WD_W-1:0] pendData;
  logic [SL_W-1:0] pendSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg  <= '0;
      pendData <= '0;
      pendSel  <= '0;
      maskOn   <= 1'b0;
    end else begin
      if (strobe.loadData) dataReg <= busWrData;
      if (strobe.latchCmd) begin
        pendData <= dataReg;
        pendSel  <= busWrData[SL_W-1:0];
      end
      if (strobe.setMask) maskOn <= busWrData[0];
    end
  end

  // one storage word per fuse row; programming can only set bits
  for (genvar g = 0; g < NUM_W; g++) begin : gWord
    logic [WD_W-1:0] wordQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        wordQ <= '0;
      else if (strobe.commit && (pendSel == SL_W'(g)))
        wordQ <= wordQ | pendData;
    end
    assign fuseArray[g*WD_W +: WD_W] = wordQ;
  end

  always_comb begin
    busRdData = '0;
    for (int i = 0; i < NUM_W; i++) begin
      if (busAddr == ADR_W'(i)) begin
        if (!supplyOk)
          busRdData = '1;
        else if (maskOn && (i != 0))
          busRdData = '0;
        else
          busRdData = fuseArray[i*WD_W +: WD_W];
      end
    end
    if (busAddr == ADR_DATA) busRdData = dataReg;
    if (busAddr == ADR_MASK) busRdData = {{(WD_W-1){1'b0}}, maskOn};
    if (busAddr == ADR_STAT) begin
      busRdData            = '0;
      busRdData[ST_BUSY]   = busy;
      busRdData[ST_ERR]    = errFlag;
      busRdData[ST_MASK]   = maskOn;
      busRdData[ST_SUPPLY] = supplyOk;
    end
  end
endmodule

// File: rtl/fuse_bank.sv
module fuse_bank
  import fuse_pkg::*;
#(
  parameter int NUM_W = NUM_WORDS,
  parameter int WD_W  = WORD_W,
  parameter int ADR_W = ADDR_W,
  parameter int SL_W  = SEL_W,
  parameter int P_CYC = PROG_CYCLES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             supplyOk,
  input  logic             busWrEn,
  input  logic [ADR_W-1:0] busAddr,
  input  logic [WD_W-1:0]  busWrData,
  output logic [WD_W-1:0]  busRdData
);
  fuseStrobe_t              strobe;
  logic                     busy;
  logic                     errFlag;
  logic                     maskLocked;
  logic                     maskOn;
  logic [NUM_W*WD_W-1:0]    fuseArray;

  fuse_ctrl #(
    .NUM_W(NUM_W), .ADR_W(ADR_W), .SL_W(SL_W), .P_CYC(P_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk),
    .busWrEn(busWrEn), .busAddr(busAddr), .selIn(busWrData[SL_W-1:0]),
    .strobe(strobe), .busy(busy), .errFlag(errFlag), .maskLocked(maskLocked)
  );

  fuse_datapath #(
    .NUM_W(NUM_W), .WD_W(WD_W), .ADR_W(ADR_W), .SL_W(SL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .supplyOk(supplyOk),
    .busy(busy), .errFlag(errFlag), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .fuseArray(fuseArray), .maskOn(maskOn)
  );
endmodule

// File: rtl/fuse_bank_chk.sv
module fuse_bank_chk
  import fuse_pkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic                        supplyOk,
  input logic                        busWrEn,
  input logic [ADDR_W-1:0]           busAddr,
  input logic [SEL_W-1:0]            selBits,
  input logic [WORD_W-1:0]           busRdData,
  input logic [NUM_WORDS*WORD_W-1:0] fuseArray,
  input logic                        maskOn,
  input logic                        maskLocked,
  input logic                        busy,
  input logic                        errFlag,
  input fuseStrobe_t                 strobe
);
  logic cmdWr;
  assign cmdWr = busWrEn && (busAddr == 4'd11);

  // R2: word 0 is never hidden while the rail is present
  assert_word0_visible_R2: assert property (@(posedge clk) disable iff (!rstN)
    (supplyOk && busAddr == 4'd0) |-> (busRdData == fuseArray[WORD_W-1:0]));

  // R3: stored bits never fall
  assert_set_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((fuseArray & $past(fuseArray)) == $past(fuseArray)));

  // R4: no new command is taken while programming runs
  assert_busy_blocks_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobe.latchCmd);

  // R5: out-of-range select raises the error and leaves storage alone
  assert_bad_sel_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !busy && selBits >= 4'd10) |=> (errFlag && $stable(fuseArray)));

  // R6: once written, the mask never changes
  assert_mask_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    maskLocked |=> (maskLocked && $stable(maskOn)));

  // R7: masked words read zero
  assert_mask_blank_R7: assert property (@(posedge clk) disable iff (!rstN)
    (supplyOk && maskOn && busAddr >= 4'd1 && busAddr <= 4'd9) |-> (busRdData == '0));

  // R8: floating rail reads all ones
  assert_float_ones_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!supplyOk && busAddr <= 4'd9) |-> (busRdData == '1));

  // R9: nothing is accepted or committed without the rail
  assert_float_nocommit_R9: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |-> (!strobe.commit && !strobe.latchCmd));
endmodule

bind fuse_bank fuse_bank_chk u_chk (
  .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .busWrEn(busWrEn),
  .busAddr(busAddr), .selBits(busWrData[3:0]), .busRdData(busRdData),
  .fuseArray(fuseArray), .maskOn(maskOn), .maskLocked(maskLocked),
  .busy(busy), .errFlag(errFlag), .strobe(strobe)
);

// File: tb/fuse_bank_tb.sv
`timescale 1ns/1ps
module fuse_bank_tb;
  localparam int P = 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic        supplyOk;
  logic        busWrEn;
  logic [3:0]  busAddr;
  logic [31:0] busWrData;
  logic [31:0] busRdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  logic [31:0] mWord [10];
  logic [31:0] mData, mPData;
  int          mPSel, mCnt;
  bit          mErr, mMask, mLocked;

  always #2.5 clk = ~clk;

  fuse_bank u_dut (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 10; i++) mWord[i] = '0;
    mData = '0; mPData = '0; mPSel = 0; mCnt = 0;
    mErr = 0; mMask = 0; mLocked = 0;
  endtask

  function automatic logic [31:0] modelRead(int a);
    logic [31:0] r;
    r = '0;
    if (a < 10) begin
      if (!supplyOk) r = '1;
      else if (mMask && a != 0) r = '0;
      else r = mWord[a];
    end else if (a == 10) r = mData;
    else if (a == 12) r = {31'b0, mMask};
    else if (a == 13) r = {28'b0, supplyOk, mMask, mErr, (mCnt != 0)};
    return r;
  endfunction

  function automatic string tagFor(int a);
    if (a < 10) return !supplyOk ? "R8" : ((mMask && a != 0) ? "R7" : "R2");
    if (a == 13) return "R4";
    return "R10";
  endfunction

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      int oldCnt;
      oldCnt = mCnt;
      if (mCnt > 0) begin
        mCnt--;
        if (mCnt == 0) begin
          if (supplyOk) mWord[mPSel] = mWord[mPSel] | mPData;
          else mErr = 1;
        end
      end
      if (busWrEn) begin
        case (busAddr)
          4'd10: mData = busWrData;
          4'd11: if (oldCnt == 0) begin
                   if (!supplyOk || busWrData[3:0] > 4'd9) mErr = 1;
                   else begin
                     mCnt = P; mPSel = int'(busWrData[3:0]); mPData = mData;
                   end
                 end
          4'd12: if (!mLocked) begin mMask = busWrData[0]; mLocked = 1; end
          default: ;
        endcase
      end
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN === 1'b1 && !done)
      check(tagFor(int'(busAddr)), busRdData, modelRead(int'(busAddr)));
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); #1;
    busWrEn = 1'b1; busAddr = 4'(a); busWrData = d;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic expectRead(int a, logic [31:0] exp, string tag);
    @(negedge clk); #1;
    busAddr = 4'(a);
    @(negedge clk);
    check(tag, busRdData, exp);
  endtask

  task automatic waitIdle();
    repeat (P + 2) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk); #1;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    rstN = 1'b0; supplyOk = 1'b1; busWrEn = 1'b0; busAddr = '0; busWrData = '0;
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    expectRead(13, 32'h8, "R1");
    expectRead(5, 32'h0, "R1");
    expectRead(10, 32'h0, "R1");

    // R3 / R4 programming and busy length
    wr(10, 32'h0000_00F0);
    wr(11, 32'd3);
    begin
      int n = 0;
      busAddr = 4'd13;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (busRdData[0]) n++;
        else break;
      end
      check("R4 busy cycles", 32'(n), 32'(P));
    end
    expectRead(3, 32'h0000_00F0, "R3");
    wr(10, 32'h0000_0101);
    wr(11, 32'd3);
    waitIdle();
    expectRead(3, 32'h0000_01F1, "R3");

    // R4 command during busy ignored
    wr(10, 32'h0000_00AA);
    wr(11, 32'd5);
    wr(11, 32'd6);
    waitIdle();
    expectRead(6, 32'h0, "R4");
    expectRead(5, 32'h0000_00AA, "R4");
    expectRead(13, 32'h8, "R4");

    // R5 out-of-range select
    wr(10, 32'h0000_FFFF);
    wr(11, 32'd12);
    expectRead(13, 32'hA, "R5");
    waitIdle();
    expectRead(2, 32'h0, "R5");
    expectRead(4, 32'h0, "R5");

    // R2 boundary words
    wr(10, 32'h8000_0001);
    wr(11, 32'd9);
    waitIdle();
    expectRead(9, 32'h8000_0001, "R2");
    wr(11, 32'd0);
    waitIdle();
    expectRead(0, 32'h8000_0001, "R2");

    // R6 first write of 0 locks the mask off
    wr(12, 32'd0);
    wr(12, 32'd1);
    expectRead(13, 32'hA, "R6");
    expectRead(3, 32'h0000_01F1, "R6");

    doReset();
    wr(10, 32'h0000_00C3);
    wr(11, 32'd0);
    waitIdle();
    wr(10, 32'h0000_003C);
    wr(11, 32'd7);
    waitIdle();

    // R8 floating rail
    @(negedge clk); #1 supplyOk = 1'b0;
    expectRead(7, 32'hFFFF_FFFF, "R8");
    expectRead(0, 32'hFFFF_FFFF, "R8");

    // R9 command refused while floating
    wr(10, 32'h0000_000F);
    wr(11, 32'd2);
    expectRead(13, 32'h2, "R9");
    @(negedge clk); #1 supplyOk = 1'b1;
    expectRead(2, 32'h0, "R9");
    expectRead(7, 32'h0000_003C, "R8");

    // R6 / R7 mask set, second write ignored
    wr(12, 32'd1);
    wr(12, 32'd0);
    expectRead(13, 32'hE, "R6");
    expectRead(7, 32'h0, "R7");
    expectRead(0, 32'h0000_00C3, "R7");
    @(negedge clk); #1 supplyOk = 1'b0;
    expectRead(7, 32'hFFFF_FFFF, "R8");
    @(negedge clk); #1 supplyOk = 1'b1;

    // R10 readback and unmapped offsets
    expectRead(10, 32'h0000_000F, "R10");
    expectRead(11, 32'h0, "R10");
    expectRead(14, 32'h0, "R10");
    expectRead(15, 32'h0, "R10");

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog R4 actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule